// File: doc/BRIEF.md
# DRBG Working-State Store

This block keeps the working state of every deterministic random bit generator instance on the chip, one entry per application port. Each entry carries a 32-bit reseed counter, a 128-bit V value, a 256-bit key, a flag that marks the instance as live, and a flag that records whether the instance was seeded from compliant entropy. The cipher and update arithmetic sit upstream.

When the cipher pipeline finishes a command, it presents one write-back carrying:
- the port index;
- the command code;
- the new V, key and counter;
- for a generate, the 128-bit output word.

The store decodes the command against the current entry and updates the entry in the same clock edge. One cycle later it returns an acknowledge with a status code to the originating port. If the command was a generate, the output word and its compliance flag go back in that same cycle.

Reseed, update and generate need a live instance. When they target an instance that is not live, the entry is left untouched, the acknowledge carries an error status, and an exception pulse is raised on that port. Uninstantiate clears the whole entry to zero. A separate combinational read port shows any entry to the cipher pipeline.

Top module: `drbg_state_store`

## Requirements
- R1: After reset every entry reads as all zeros, and no acknowledge, exception or output-valid bit is set.
- R2: The read port presents an entry with the reseed counter in bits 31:0, V in bits 159:32, key in bits 415:160, the live flag in bit 416 and the compliance flag in bit 417.
- R3: An instantiate write-back (command code 1) stores V, key and counter and sets the live flag. In the next cycle only that port's acknowledge bit is high, with status 0 (success).
- R4: Instantiate and reseed set the compliance flag as follows:
  - when the force input is high, the flag is 1, whatever the other inputs;
  - otherwise, when the deterministic-seed input is high, the flag is 0;
  - otherwise, the flag takes the entropy-compliant input.
- R5: Reseed (code 2) and update (code 4) on a live instance replace V, key and counter together in one edge. Update leaves the compliance flag unchanged.
- R6: Generate (code 3) on a live instance does three things:
  - it updates V, key and counter;
  - in the next cycle it raises the output-valid bit of that port, with the output word and the instance's stored compliance flag;
  - in that same cycle it gives an acknowledge with status 0.
- R7: Reseed, update or generate on an instance that is not live does the following:
  - the entry is left unchanged;
  - an acknowledge with status 1 is returned;
  - an exception pulse appears on that port in the acknowledge cycle;
  - no output word is returned.
- R8: Uninstantiate (code 5) zeroes every field of the entry, live or not, and acknowledges with status 0.
- R9: Command codes 0, 6 and 7 change no entry, acknowledge with status 2 and raise no exception.
- R10: A write-back changes only the entry selected by its port index.
- R11: During the cycle in which a write-back is presented, the read port still shows the old entry. It shows the new entry after the clock edge.
- R12: At most one acknowledge bit is high per cycle. Every accepted write-back produces exactly one acknowledge, including back-to-back write-backs on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_valid | input | 1 | Write-back present this cycle |
| wb_inst | input | IDX_W | Port / instance index of the write-back |
| wb_cmd | input | 3 | Command code (1 inst, 2 reseed, 3 gen, 4 update, 5 uninst) |
| wb_ctr | input | 32 | New reseed counter |
| wb_v | input | 128 | New V value |
| wb_key | input | 256 | New key |
| wb_det_seed | input | 1 | Seed was fully deterministic (caller-supplied) |
| wb_ent_ok | input | 1 | Seed entropy was compliant |
| wb_bits | input | 128 | Generated output word |
| force_comp | input | 1 | Force the compliance flag to set on instantiate/reseed |
| rd_inst | input | IDX_W | Read-port entry index |
| rd_state | output | 418 | Selected entry, packed as in R2 |
| rsp_ack | output | NUM_INST | One-cycle acknowledge per port |
| rsp_sts | output | 2 | Status of the acknowledge (0 ok, 1 not live, 2 bad command) |
| rsp_exc | output | NUM_INST | Exception pulse per port |
| gen_valid | output | NUM_INST | Output word valid per port |
| gen_bits | output | 128 | Output word |
| gen_fips | output | 1 | Compliance flag of the output word |

## Verification
The read port and the write-back port can act on the same entry in one cycle. The bench provokes this by pointing the read index at the instance being written while the write-back is presented. It samples the read port before the edge and expects the old entry, then samples it after the edge and expects the new one. A second overlap is a generate's output word and its acknowledge, which appear together in one cycle. A scoreboard checks them as a single expected item, so a split or misrouted pulse counts as a miscompare.

// File: rtl/drbg_state_pkg.sv
// Package: shared widths, command codes, status codes and the entry layout
// of the DRBG working-state store. The packed struct order fixes the bit
// positions seen on the read port (counter lowest, compliance highest).
package drbg_state_pkg;

    localparam int unsigned CTR_W   = 32;
    localparam int unsigned V_W     = 128;
    localparam int unsigned KEY_W   = 256;
    localparam int unsigned ENTRY_W = CTR_W + V_W + KEY_W + 2;
    localparam int unsigned CMD_W   = 3;

    localparam logic [CMD_W-1:0] CMD_INST   = 3'd1;
    localparam logic [CMD_W-1:0] CMD_RESEED = 3'd2;
    localparam logic [CMD_W-1:0] CMD_GEN    = 3'd3;
    localparam logic [CMD_W-1:0] CMD_UPDATE = 3'd4;
    localparam logic [CMD_W-1:0] CMD_UNINST = 3'd5;

    typedef enum logic [1:0] {
        STS_OK       = 2'd0,
        STS_NOT_LIVE = 2'd1,
        STS_BAD_CMD  = 2'd2
    } sts_e;

    typedef struct packed {
        logic             comp;
        logic             live;
        logic [KEY_W-1:0] key;
        logic [V_W-1:0]   v;
        logic [CTR_W-1:0] ctr;
    } entry_t;

endpackage

// File: rtl/drbg_cmd_decode.sv
// Module: drbg_cmd_decode
// Combinational decision for one write-back: given the command and the
// current entry of the addressed instance, produce the next entry, a write
// enable, the response status and the exception/generate flags.
// Assumes the caller gates the result with the write-back valid.
module drbg_cmd_decode
    import drbg_state_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    input  entry_t           cur,
    input  logic [CTR_W-1:0] new_ctr,
    input  logic [V_W-1:0]   new_v,
    input  logic [KEY_W-1:0] new_key,
    input  logic             det_seed,
    input  logic             ent_ok,
    input  logic             force_comp,
    output entry_t           nxt,
    output logic             wr,
    output sts_e             sts,
    output logic             exc,
    output logic             gen
);

    logic comp_seed;

    // Compliance of a fresh seed: force wins, a deterministic seed clears it.
    assign comp_seed = force_comp | (ent_ok & ~det_seed);

    // Command decision against the live flag of the current entry.
    always_comb begin
        nxt = cur;
        wr  = 1'b0;
        sts = STS_OK;
        exc = 1'b0;
        gen = 1'b0;
        unique case (cmd)
            CMD_INST: begin
                nxt.comp = comp_seed;
                nxt.live = 1'b1;
                nxt.key  = new_key;
                nxt.v    = new_v;
                nxt.ctr  = new_ctr;
                wr       = 1'b1;
            end
            CMD_RESEED, CMD_UPDATE, CMD_GEN: begin
                if (cur.live) begin
                    nxt.key = new_key;
                    nxt.v   = new_v;
                    nxt.ctr = new_ctr;
                    if (cmd == CMD_RESEED) begin
                        nxt.comp = comp_seed;
                    end
                    gen = (cmd == CMD_GEN);
                    wr  = 1'b1;
                end else begin
                    sts = STS_NOT_LIVE;
                    exc = 1'b1;
                end
            end
            CMD_UNINST: begin
                nxt = '0;
                wr  = 1'b1;
            end
            default: begin
                sts = STS_BAD_CMD;
            end
        endcase
    end

endmodule

// File: rtl/drbg_state_bank.sv
// Module: drbg_state_bank
// Register file of NUM_INST entries with one write port and two
// combinational read ports (one for the decoder, one for the pipeline).
// Assumes at most one write per cycle; reads show the pre-edge contents.
module drbg_state_bank
    import drbg_state_pkg::*;
#(
    parameter int unsigned NUM_INST = 4,
    parameter int unsigned IDX_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  entry_t           wr_data,
    input  logic [IDX_W-1:0] a_idx,
    input  logic [IDX_W-1:0] b_idx,
    output entry_t           a_data,
    output entry_t           b_data
);

    entry_t              mem [NUM_INST];
    logic [NUM_INST-1:0] we;

    // Per-entry write enables decoded from the write index.
    for (genvar g = 0; g < NUM_INST; g++) begin : g_we
        assign we[g] = wr_en && (wr_idx == IDX_W'(g));
    end

    // Entry storage: cleared by reset, replaced whole on its enable.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_INST; i++) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (we[i]) begin
                mem[i] <= wr_data;
            end
        end
    end

    // Read muxes; an index beyond the table reads as zero.
    always_comb begin
        a_data = '0;
        b_data = '0;
        for (int i = 0; i < NUM_INST; i++) begin
            if (a_idx == IDX_W'(i)) a_data = mem[i];
            if (b_idx == IDX_W'(i)) b_data = mem[i];
        end
    end

endmodule

// File: rtl/drbg_rsp_gen.sv
// Module: drbg_rsp_gen
// Registers the response of an accepted write-back: one-hot acknowledge,
// status, exception pulse and output word, all valid one cycle later.
// Assumes fire is high only for an in-range index.
module drbg_rsp_gen
    import drbg_state_pkg::*;
#(
    parameter int unsigned NUM_INST = 4,
    parameter int unsigned IDX_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fire,
    input  logic [IDX_W-1:0]    idx,
    input  sts_e                sts_in,
    input  logic                exc_in,
    input  logic                gen_in,
    input  logic [V_W-1:0]      bits_in,
    input  logic                fips_in,
    output logic [NUM_INST-1:0] ack_q,
    output sts_e                sts_q,
    output logic [NUM_INST-1:0] exc_q,
    output logic [NUM_INST-1:0] gv_q,
    output logic [V_W-1:0]      bits_q,
    output logic                fips_q
);

    logic [NUM_INST-1:0] sel;

    // One-hot port select of the current write-back.
    assign sel = fire ? (NUM_INST'(1) << idx) : '0;

    // Response registers; pulses last exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q  <= '0;
            sts_q  <= STS_OK;
            exc_q  <= '0;
            gv_q   <= '0;
            bits_q <= '0;
            fips_q <= 1'b0;
        end else begin
            ack_q <= sel;
            sts_q <= fire ? sts_in : STS_OK;
            exc_q <= exc_in ? sel : '0;
            gv_q  <= gen_in ? sel : '0;
            if (fire && gen_in) begin
                bits_q <= bits_in;
                fips_q <= fips_in;
            end
        end
    end

endmodule

// File: rtl/drbg_state_store.sv
// Module: drbg_state_store (top)
// Per-port working-state store of the random bit generator instances.
// Accepts one write-back per cycle from the cipher pipeline, updates the
// addressed entry at the edge and acknowledges the port one cycle later.
// Assumes the upstream pipeline has finished all arithmetic.
module drbg_state_store
    import drbg_state_pkg::*;
#(
    parameter  int unsigned NUM_INST = 4,
    localparam int unsigned IDX_W    = (NUM_INST > 1) ? $clog2(NUM_INST) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wb_valid,
    input  logic [IDX_W-1:0]    wb_inst,
    input  logic [CMD_W-1:0]    wb_cmd,
    input  logic [CTR_W-1:0]    wb_ctr,
    input  logic [V_W-1:0]      wb_v,
    input  logic [KEY_W-1:0]    wb_key,
    input  logic                wb_det_seed,
    input  logic                wb_ent_ok,
    input  logic [V_W-1:0]      wb_bits,
    input  logic                force_comp,
    input  logic [IDX_W-1:0]    rd_inst,
    output logic [ENTRY_W-1:0]  rd_state,
    output logic [NUM_INST-1:0] rsp_ack,
    output logic [1:0]          rsp_sts,
    output logic [NUM_INST-1:0] rsp_exc,
    output logic [NUM_INST-1:0] gen_valid,
    output logic [V_W-1:0]      gen_bits,
    output logic                gen_fips
);

    entry_t cur_e, nxt_e, rd_e;
    logic   fire, dec_wr, dec_exc, dec_gen;
    sts_e   dec_sts, sts_q;

    // Accept only write-backs whose index names an existing entry.
    assign fire = wb_valid && (int'(wb_inst) < NUM_INST);

    drbg_state_bank #(.NUM_INST(NUM_INST), .IDX_W(IDX_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fire && dec_wr),
        .wr_idx  (wb_inst),
        .wr_data (nxt_e),
        .a_idx   (wb_inst),
        .b_idx   (rd_inst),
        .a_data  (cur_e),
        .b_data  (rd_e)
    );

    drbg_cmd_decode u_dec (
        .cmd        (wb_cmd),
        .cur        (cur_e),
        .new_ctr    (wb_ctr),
        .new_v      (wb_v),
        .new_key    (wb_key),
        .det_seed   (wb_det_seed),
        .ent_ok     (wb_ent_ok),
        .force_comp (force_comp),
        .nxt        (nxt_e),
        .wr         (dec_wr),
        .sts        (dec_sts),
        .exc        (dec_exc),
        .gen        (dec_gen)
    );

    drbg_rsp_gen #(.NUM_INST(NUM_INST), .IDX_W(IDX_W)) u_rsp (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .idx     (wb_inst),
        .sts_in  (dec_sts),
        .exc_in  (dec_exc),
        .gen_in  (dec_gen),
        .bits_in (wb_bits),
        .fips_in (cur_e.comp),
        .ack_q   (rsp_ack),
        .sts_q   (sts_q),
        .exc_q   (rsp_exc),
        .gv_q    (gen_valid),
        .bits_q  (gen_bits),
        .fips_q  (gen_fips)
    );

    assign rd_state = rd_e;
    assign rsp_sts  = sts_q;

endmodule

// File: rtl/drbg_state_store_chk.sv
// Module: drbg_state_store_chk
// Port-level assertions for drbg_state_store, attached by bind below.
module drbg_state_store_chk
    import drbg_state_pkg::*;
#(
    parameter int unsigned NUM_INST = 4,
    parameter int unsigned IDX_W    = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wb_valid,
    input logic [IDX_W-1:0]    wb_inst,
    input logic [CMD_W-1:0]    wb_cmd,
    input logic [IDX_W-1:0]    rd_inst,
    input logic [ENTRY_W-1:0]  rd_state,
    input logic [NUM_INST-1:0] rsp_ack,
    input logic [1:0]          rsp_sts,
    input logic [NUM_INST-1:0] rsp_exc,
    input logic [NUM_INST-1:0] gen_valid
);

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_ack)); // R12

    AST_ACK_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && int'(wb_inst) < NUM_INST) |=> (rsp_ack == (NUM_INST'(1) << $past(wb_inst)))); // R3

    AST_ACK_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|rsp_ack) |-> $past(wb_valid)); // R12

    AST_EXC_IS_ERR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (|rsp_exc) |-> (rsp_exc == rsp_ack && rsp_sts == 2'd1 && gen_valid == '0)); // R7

    AST_GEN_IS_OK_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (|gen_valid) |-> (gen_valid == rsp_ack && rsp_sts == 2'd0)); // R6

    AST_BAD_NO_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        ((|rsp_ack) && rsp_sts == 2'd2) |-> (rsp_exc == '0)); // R9

    AST_UNINST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_cmd == CMD_UNINST && rd_inst == wb_inst && int'(wb_inst) < NUM_INST)
        |=> (rd_inst != $past(rd_inst) || rd_state == '0)); // R8

endmodule

bind drbg_state_store drbg_state_store_chk #(.NUM_INST(NUM_INST), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wb_valid  (wb_valid),
    .wb_inst   (wb_inst),
    .wb_cmd    (wb_cmd),
    .rd_inst   (rd_inst),
    .rd_state  (rd_state),
    .rsp_ack   (rsp_ack),
    .rsp_sts   (rsp_sts),
    .rsp_exc   (rsp_exc),
    .gen_valid (gen_valid)
);

// File: tb/tb_drbg_state_store.sv
// Scoreboard bench: the driver task predicts each response into a queue,
// the monitor pops and compares whenever the design responds.
module tb_drbg_state_store;
    import drbg_state_pkg::*;

    localparam int N = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic               rst_n;
    logic               wb_valid;
    logic [1:0]         wb_inst;
    logic [2:0]         wb_cmd;
    logic [31:0]        wb_ctr;
    logic [127:0]       wb_v;
    logic [255:0]       wb_key;
    logic               wb_det_seed;
    logic               wb_ent_ok;
    logic [127:0]       wb_bits;
    logic               force_comp;
    logic [1:0]         rd_inst;
    logic [417:0]       rd_state;
    logic [N-1:0]       rsp_ack;
    logic [1:0]         rsp_sts;
    logic [N-1:0]       rsp_exc;
    logic [N-1:0]       gen_valid;
    logic [127:0]       gen_bits;
    logic               gen_fips;

    drbg_state_store #(.NUM_INST(N)) dut (
        .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_inst(wb_inst),
        .wb_cmd(wb_cmd), .wb_ctr(wb_ctr), .wb_v(wb_v), .wb_key(wb_key),
        .wb_det_seed(wb_det_seed), .wb_ent_ok(wb_ent_ok), .wb_bits(wb_bits),
        .force_comp(force_comp), .rd_inst(rd_inst), .rd_state(rd_state),
        .rsp_ack(rsp_ack), .rsp_sts(rsp_sts), .rsp_exc(rsp_exc),
        .gen_valid(gen_valid), .gen_bits(gen_bits), .gen_fips(gen_fips)
    );

    // Reference model of the entries
    logic         m_comp [N];
    logic         m_live [N];
    logic [255:0] m_key  [N];
    logic [127:0] m_v    [N];
    logic [31:0]  m_ctr  [N];

    typedef struct {
        logic [N-1:0] ack;
        logic [1:0]   sts;
        logic [N-1:0] exc;
        logic [N-1:0] gv;
        logic [127:0] bits;
        logic         fips;
        string        tag;
    } exp_t;

    exp_t expq[$];
    int   nchk = 0;
    int   nfail = 0;
    bit   run = 1'b0;

    function automatic logic [417:0] model(int i);
        return {m_comp[i], m_live[i], m_key[i], m_v[i], m_ctr[i]};
    endfunction

    function automatic logic [127:0] mk_v(int n);
        return {4{32'hA500_0000 + 32'(n)}};
    endfunction
    function automatic logic [255:0] mk_key(int n);
        return {8{32'hC300_0000 + 32'(n)}};
    endfunction
    function automatic logic [127:0] mk_bits(int n);
        return {4{32'h5A00_0000 + 32'(n)}};
    endfunction

    task automatic chk(bit ok, string tag, logic [417:0] act, logic [417:0] expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Read one entry through the read port and compare; ends at a negedge.
    task automatic chk_state(int i, string tag);
        rd_inst = i[1:0];
        #1;
        chk(rd_state == model(i), tag, rd_state, model(i));
        @(negedge clk);
    endtask

    // Drive one write-back at a negedge, predict its response, update model.
    task automatic drive(int i, logic [2:0] c, int n, logic det, logic ent,
                         logic frc, string tag, bit same = 1'b0);
        exp_t         e;
        logic [N-1:0] sel;
        logic         cnew;
        wb_valid    = 1'b1;
        wb_inst     = i[1:0];
        wb_cmd      = c;
        wb_ctr      = 32'(n);
        wb_v        = mk_v(n);
        wb_key      = mk_key(n);
        wb_bits     = mk_bits(n);
        wb_det_seed = det;
        wb_ent_ok   = ent;
        force_comp  = frc;
        sel    = N'(1) << i;
        cnew   = frc | (ent & ~det);
        e.ack  = sel; e.sts = 2'd0; e.exc = '0; e.gv = '0;
        e.bits = '0;  e.fips = 1'b0; e.tag = tag;
        if (same) begin
            rd_inst = i[1:0];
            #1;
            chk(rd_state == model(i), "R11 read shows old entry in write cycle", rd_state, model(i));
        end
        case (c)
            3'd1: begin
                m_v[i] = mk_v(n); m_key[i] = mk_key(n); m_ctr[i] = 32'(n);
                m_live[i] = 1'b1; m_comp[i] = cnew;
            end
            3'd2, 3'd3, 3'd4: begin
                if (!m_live[i]) begin
                    e.sts = 2'd1; e.exc = sel;
                end else begin
                    if (c == 3'd3) begin
                        e.gv = sel; e.bits = mk_bits(n); e.fips = m_comp[i];
                    end
                    if (c == 3'd2) m_comp[i] = cnew;
                    m_v[i] = mk_v(n); m_key[i] = mk_key(n); m_ctr[i] = 32'(n);
                end
            end
            3'd5: begin
                m_v[i] = '0; m_key[i] = '0; m_ctr[i] = '0;
                m_live[i] = 1'b0; m_comp[i] = 1'b0;
            end
            default: e.sts = 2'd2;
        endcase
        expq.push_back(e);
        @(negedge clk);
        wb_valid = 1'b0;
    endtask

    // Monitor: compare every response cycle with the oldest prediction.
    exp_t mon_e;
    bit   mon_ok;
    always @(negedge clk) begin
        if (run && rst_n && ((|rsp_ack) || (|rsp_exc) || (|gen_valid))) begin
            nchk++;
            if (expq.size() == 0) begin
                nfail++;
                $display("FAIL R12 unexpected response actual ack=%b exc=%b gv=%b expected none",
                         rsp_ack, rsp_exc, gen_valid);
            end else begin
                mon_e  = expq.pop_front();
                mon_ok = (rsp_ack == mon_e.ack) && (rsp_sts == mon_e.sts) &&
                         (rsp_exc == mon_e.exc) && (gen_valid == mon_e.gv) &&
                         (mon_e.gv == '0 || (gen_bits == mon_e.bits && gen_fips == mon_e.fips));
                if (!mon_ok) begin
                    nfail++;
                    $display("FAIL %s actual ack=%b sts=%0d exc=%b gv=%b bits=%h fips=%b expected ack=%b sts=%0d exc=%b gv=%b bits=%h fips=%b",
                             mon_e.tag, rsp_ack, rsp_sts, rsp_exc, gen_valid, gen_bits, gen_fips,
                             mon_e.ack, mon_e.sts, mon_e.exc, mon_e.gv, mon_e.bits, mon_e.fips);
                end
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    // Watchdog: a hung run is one failed check and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; wb_valid = 1'b0; wb_inst = '0; wb_cmd = '0; wb_ctr = '0;
        wb_v = '0; wb_key = '0; wb_det_seed = 1'b0; wb_ent_ok = 1'b0;
        wb_bits = '0; force_comp = 1'b0; rd_inst = '0;
        for (int i = 0; i < N; i++) begin
            m_comp[i] = 1'b0; m_live[i] = 1'b0; m_key[i] = '0; m_v[i] = '0; m_ctr[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        run = 1'b1;

        // R1: reset state
        for (int i = 0; i < N; i++) chk_state(i, "R1 entry zero after reset");
        chk({rsp_ack, rsp_exc, gen_valid} == '0, "R1 no pulses after reset",
            418'({rsp_ack, rsp_exc, gen_valid}), '0);

        // R7: commands on an instance that is not live
        drive(0, 3'd3, 1, 0, 1, 0, "R7 generate on non-live instance");
        chk_state(0, "R7 entry unchanged after generate on non-live");
        drive(0, 3'd2, 2, 0, 1, 0, "R7 reseed on non-live instance");
        drive(0, 3'd4, 3, 0, 1, 0, "R7 update on non-live instance");
        chk_state(0, "R7 entry unchanged after reseed/update on non-live");

        // R9: bad command codes
        drive(1, 3'd6, 4, 0, 1, 0, "R9 code 6 rejected");
        drive(1, 3'd0, 5, 0, 1, 0, "R9 code 0 rejected");
        chk_state(1, "R9 entry unchanged after bad codes");

        // R3, R4, R2: instantiate with compliant entropy
        drive(0, 3'd1, 7, 0, 1, 0, "R3 instantiate acknowledged");
        chk_state(0, "R3 instantiate stores entry");
        rd_inst = 2'd0;
        #1;
        chk(rd_state[31:0] == 32'd7, "R2 counter at 31:0", 418'(rd_state[31:0]), 418'(7));
        chk(rd_state[159:32] == mk_v(7), "R2 V at 159:32", 418'(rd_state[159:32]), 418'(mk_v(7)));
        chk(rd_state[415:160] == mk_key(7), "R2 key at 415:160", 418'(rd_state[415:160]), 418'(mk_key(7)));
        chk(rd_state[417:416] == 2'b11, "R2 flags at 417:416 (R4 compliant)", 418'(rd_state[417:416]), 418'(2'b11));
        @(negedge clk);

        // R4: deterministic seed clears, force sets
        drive(1, 3'd1, 8, 1, 1, 0, "R4 instantiate deterministic");
        chk_state(1, "R4 deterministic seed clears compliance");
        drive(2, 3'd1, 9, 1, 0, 1, "R4 instantiate forced");
        chk_state(2, "R4 force sets compliance");

        // R6 with R11: generate while reading the same entry
        drive(0, 3'd3, 10, 0, 0, 0, "R6 generate compliant instance", 1'b1);
        chk_state(0, "R11 read shows new entry after edge");
        drive(1, 3'd3, 11, 0, 1, 0, "R6 generate non-compliant instance");
        drive(2, 3'd3, 12, 0, 0, 0, "R6 generate forced instance");
        chk_state(1, "R6 generate updates entry");

        // R5: update keeps compliance, reseed recomputes it
        drive(1, 3'd4, 13, 0, 1, 1, "R5 update acknowledged");
        chk_state(1, "R5 update keeps compliance flag");
        drive(1, 3'd2, 14, 0, 1, 0, "R5 reseed acknowledged");
        chk_state(1, "R5 R4 reseed replaces state and sets compliance");

        // R10: untouched entries
        chk_state(3, "R10 unused entry untouched");
        chk_state(2, "R10 other entry untouched");

        // R9: bad code on a live entry leaves it alone
        drive(0, 3'd7, 15, 0, 1, 0, "R9 code 7 rejected on live entry");
        chk_state(0, "R9 live entry unchanged by code 7");

        // R8: uninstantiate live and non-live entries
        drive(0, 3'd5, 16, 0, 1, 0, "R8 uninstantiate live", 1'b1);
        chk_state(0, "R8 entry zeroed");
        drive(3, 3'd5, 17, 0, 1, 0, "R8 uninstantiate non-live");
        chk_state(3, "R8 non-live entry stays zero");
        drive(0, 3'd2, 18, 0, 1, 0, "R7 reseed after uninstantiate");
        chk_state(0, "R7 entry still zero after rejected reseed");

        // R12: back-to-back write-backs on consecutive cycles
        drive(3, 3'd1, 20, 0, 1, 0, "R12 burst instantiate");
        drive(3, 3'd3, 21, 0, 0, 0, "R12 burst generate");
        drive(2, 3'd4, 22, 0, 0, 0, "R12 burst update");
        drive(0, 3'd3, 23, 0, 0, 0, "R12 burst generate on non-live");
        drive(1, 3'd6, 24, 0, 0, 0, "R12 burst bad code");
        chk_state(3, "R12 burst result entry 3");
        chk_state(2, "R12 burst result entry 2");

        repeat (3) @(negedge clk);
        chk(expq.size() == 0, "R12 every write-back acknowledged",
            418'(expq.size()), '0);
        summary();
        $finish;
    end

endmodule